// File: doc/BRIEF.md
# Cache Line Fill Sequencer

This block services a cache miss by pulling one whole line from the slower second-level on-chip SRAM through a pipelined read port one beat wide. When it accepts a miss, it stores the line-aligned address, the victim way and the fetch kind. It then issues one read per beat in ascending address order. The timing of the fill is fixed. The first beat lands `FIRST_LAT` cycles after acceptance, and each following beat lands `BEAT_GAP` cycles after the one before it. With the default parameters the line is 256 bits, made of four 64-bit beats on a 9/2/2/2 schedule, so the whole line is in place 15 cycles after the miss was taken.

Each beat is shown at the ports as soon as it is written into the line buffer. A strobe marks it, together with its index and its data. A consumer can therefore start on the critical word before the rest of the line arrives. A line-complete pulse comes with the last beat, and the assembled line stays readable afterwards. Instruction misses and data misses use the same path and the same timing. Victim selection, tags and write-back are left to the surrounding cache, which only supplies the way index.

Top module: `line_fill_seq`

## Requirements
- R1: After reset the block is idle. `miss_ready` is 1, and `beat_valid`, `line_done`, `l2_rd_en` and `beat_have` are all 0.
- R2: A miss is taken on a rising edge where `miss_valid` and `miss_ready` are both 1. From the cycle after that edge, `miss_ready` is 0 until the cycle in which `line_done` is 1, and it returns to 1 in that same cycle.
- R3: Number the cycles after the accepting edge 0, 1, 2 and so on. `l2_rd_en` is 1 only in cycles k*2, for k = 0..3. In those cycles `l2_rd_addr` equals the line base plus 8*k. At every other time `l2_rd_en` is 0.
- R4: The strobe for beat 0 appears in cycle 9 after the accepting edge.
- R5: Each later beat strobe follows two cycles after the one before it, in cycles 11, 13 and 15. Each strobe lasts one cycle, and `beat_idx` counts 0, 1, 2, 3.
- R6: The L2 port must present the data for a request 8 cycles after the request cycle (FIRST_LAT-1). `beat_data` carries the value that `l2_rdata` held in that cycle.
- R7: `line_done` is 1 only together with the strobe of beat 3. In that cycle `line_data` holds all four beats, with beat k in bits [64k+63:64k].
- R8: Bit k of `beat_have` goes to 1 when beat k lands and stays set for the rest of the line. All bits clear on the edge that accepts the next miss.
- R9: `miss_valid` has no effect while a fill is running. `fill_addr`, `fill_way`, the L2 requests and the beat timing stay the same.
- R10: Instruction misses (`miss_is_instr`=1) and data misses (0) follow the same timing. `fill_is_instr` echoes the kind of the accepted miss.
- R11: Address bits [4:0] of `miss_addr` are ignored. `fill_addr` is the line-aligned address, with those bits zero.
- R12: A synchronous reset during a fill returns the block to idle and clears `beat_have`. L2 data that arrives afterwards produces no beat strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | A miss request is present |
| miss_ready | output | 1 | Sequencer idle and able to take a miss |
| miss_addr | input | 32 | Byte address of the missing access |
| miss_way | input | 2 | Victim way chosen by the cache |
| miss_is_instr | input | 1 | 1 for an instruction miss, 0 for a data miss |
| l2_rd_en | output | 1 | L2 read request for one beat |
| l2_rd_addr | output | 32 | Byte address of the requested beat |
| l2_rdata | input | 64 | L2 read data, returned FIRST_LAT-1 cycles after the request |
| beat_valid | output | 1 | One-cycle strobe: a beat has landed |
| beat_idx | output | 2 | Index of the beat being strobed |
| beat_data | output | 64 | Data of the beat being strobed |
| beat_have | output | 4 | Beats of the current line already present |
| line_done | output | 1 | One-cycle pulse: the whole line is present |
| line_data | output | 256 | Assembled line, beat 0 in the low bits |
| fill_way | output | 2 | Way of the fill in progress or last completed |
| fill_is_instr | output | 1 | Kind of the fill in progress or last completed |
| fill_addr | output | 32 | Line-aligned address of the fill |

## Verification
Some properties are checked by assertions on every cycle. These are: L2 requests are never overlapping and never issued while idle; each beat strobe lasts one cycle; a strobe always has its `beat_have` bit set; `line_done` coincides with the final beat and a full `beat_have`; and the fill address and way hold steady while busy. The bench scenarios cover what depends on absolute cycle counts. That includes the exact 9/11/13/15 landing cycles, the addresses and data carried by each beat, and the identical timing of instruction and data misses. It also includes the ignored mid-fill requests, the clearing of `beat_have` on the next miss, and the recovery from a reset in the middle of a fill.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

   // cycle (counted from the accepting edge) in which beat k is requested
   function automatic int req_slot(input int k, input int gap);
      return k * gap;
   endfunction

   // cycle in which the returning data of beat k is sampled into the buffer
   function automatic int cap_slot(input int k, input int first, input int gap);
      return first - 1 + k * gap;
   endfunction

   // number of busy cycles for one complete line
   function automatic int fill_span(input int beats, input int first, input int gap);
      return first + gap * (beats - 1);
   endfunction

endpackage

// File: rtl/lfs_timer.sv
module lfs_timer
   import lfs_pkg::*;
#(
   parameter int BEATS     = 4,
   parameter int FIRST_LAT = 9,
   parameter int BEAT_GAP  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             busy,
   output logic [BEATS-1:0] req_hit,
   output logic [BEATS-1:0] cap_hit
);
   localparam int SPAN  = fill_span(BEATS, FIRST_LAT, BEAT_GAP);
   localparam int CNT_W = $clog2(SPAN + 1);
   localparam int LAST  = SPAN - 1;

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_W'(LAST)) busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;

   for (genvar k = 0; k < BEATS; k++) begin : g_slot
      assign req_hit[k] = busy_q && (cnt_q == CNT_W'(req_slot(k, BEAT_GAP)));
      assign cap_hit[k] = busy_q && (cnt_q == CNT_W'(cap_slot(k, FIRST_LAT, BEAT_GAP)));
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      busy_q |-> (cnt_q <= CNT_W'(LAST)));

   // R2
   no_restart_chk: assert property (@(posedge clk) disable iff (rst)
      busy_q |-> !start);

endmodule

// File: rtl/lfs_issue.sv
module lfs_issue #(
   parameter int BEATS  = 4,
   parameter int BEAT_W = 64,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy,
   input  logic [BEATS-1:0]  req_hit,
   input  logic [ADDR_W-1:0] line_base,
   output logic              l2_rd_en,
   output logic [ADDR_W-1:0] l2_rd_addr
);
   localparam int IDX_W   = $clog2(BEATS);
   localparam int BYTE_SH = $clog2(BEAT_W / 8);

   logic [IDX_W-1:0] req_idx;

   always_comb begin
      req_idx = '0;
      for (int k = 0; k < BEATS; k++) begin
         if (req_hit[k]) req_idx = req_idx | IDX_W'(k);
      end
   end

   assign l2_rd_en   = |req_hit;
   assign l2_rd_addr = line_base | (ADDR_W'(req_idx) << BYTE_SH);

   // R3
   req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(req_hit));

   // R3
   req_busy_chk: assert property (@(posedge clk) disable iff (rst)
      l2_rd_en |-> busy);

endmodule

// File: rtl/lfs_linebuf.sv
module lfs_linebuf #(
   parameter int BEATS  = 4,
   parameter int BEAT_W = 64
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clear,
   input  logic [BEATS-1:0]        cap_hit,
   input  logic [BEAT_W-1:0]       rdata,
   output logic                    beat_valid,
   output logic [$clog2(BEATS)-1:0] beat_idx,
   output logic [BEAT_W-1:0]       beat_data,
   output logic [BEATS-1:0]        beat_have,
   output logic                    line_done,
   output logic [BEATS*BEAT_W-1:0] line_data
);
   localparam int IDX_W = $clog2(BEATS);

   logic [BEAT_W-1:0] slot_q [BEATS];
   logic [BEATS-1:0]  have_q;
   logic [IDX_W-1:0]  cap_idx;

   for (genvar k = 0; k < BEATS; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst) begin
            slot_q[k] <= '0;
            have_q[k] <= 1'b0;
         end else begin
            if (clear)           have_q[k] <= 1'b0;
            else if (cap_hit[k]) have_q[k] <= 1'b1;
            if (cap_hit[k])      slot_q[k] <= rdata;
         end
      end
      assign line_data[k*BEAT_W +: BEAT_W] = slot_q[k];
   end

   always_comb begin
      cap_idx = '0;
      for (int k = 0; k < BEATS; k++) begin
         if (cap_hit[k]) cap_idx = cap_idx | IDX_W'(k);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_valid <= 1'b0;
         beat_idx   <= '0;
         beat_data  <= '0;
         line_done  <= 1'b0;
      end else begin
         beat_valid <= |cap_hit;
         line_done  <= cap_hit[BEATS-1];
         if (|cap_hit) begin
            beat_idx  <= cap_idx;
            beat_data <= rdata;
         end
      end
   end

   assign beat_have = have_q;

   // R5
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (beat_valid && beat_idx != IDX_W'(BEATS - 1)) |=> !beat_valid);

   // R8
   have_mark_chk: assert property (@(posedge clk) disable iff (rst)
      beat_valid |-> beat_have[beat_idx]);

   // R7
   done_last_chk: assert property (@(posedge clk) disable iff (rst)
      line_done |-> (beat_valid && beat_idx == IDX_W'(BEATS - 1) && (&beat_have)));

endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
   parameter int BEATS     = 4,
   parameter int BEAT_W    = 64,
   parameter int ADDR_W    = 32,
   parameter int WAY_W     = 2,
   parameter int FIRST_LAT = 9,
   parameter int BEAT_GAP  = 2,
   localparam int IDX_W    = $clog2(BEATS),
   localparam int LINE_W   = BEATS * BEAT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              miss_valid,
   output logic              miss_ready,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic [WAY_W-1:0]  miss_way,
   input  logic              miss_is_instr,
   output logic              l2_rd_en,
   output logic [ADDR_W-1:0] l2_rd_addr,
   input  logic [BEAT_W-1:0] l2_rdata,
   output logic              beat_valid,
   output logic [IDX_W-1:0]  beat_idx,
   output logic [BEAT_W-1:0] beat_data,
   output logic [BEATS-1:0]  beat_have,
   output logic              line_done,
   output logic [LINE_W-1:0] line_data,
   output logic [WAY_W-1:0]  fill_way,
   output logic              fill_is_instr,
   output logic [ADDR_W-1:0] fill_addr
);
   localparam int OFF_W = $clog2(LINE_W / 8);

   if (BEATS < 2 || (1 << IDX_W) != BEATS) begin : g_bad_beats
      $error("BEATS must be a power of two and at least 2");
   end
   if (BEAT_W < 8 || (BEAT_W % 8) != 0 || (1 << $clog2(BEAT_W)) != BEAT_W) begin : g_bad_width
      $error("BEAT_W must be a power of two number of bytes");
   end
   if (BEAT_GAP < 1 || FIRST_LAT < 2) begin : g_bad_sched
      $error("BEAT_GAP must be >= 1 and FIRST_LAT >= 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the line size");
   end

   logic             busy;
   logic             accept;
   logic [BEATS-1:0] req_hit;
   logic [BEATS-1:0] cap_hit;

   assign miss_ready = !busy;
   assign accept     = miss_valid && !busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_addr     <= '0;
         fill_way      <= '0;
         fill_is_instr <= 1'b0;
      end else if (accept) begin
         fill_addr     <= {miss_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
         fill_way      <= miss_way;
         fill_is_instr <= miss_is_instr;
      end
   end

   lfs_timer #(
      .BEATS     (BEATS),
      .FIRST_LAT (FIRST_LAT),
      .BEAT_GAP  (BEAT_GAP)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start   (accept),
      .busy    (busy),
      .req_hit (req_hit),
      .cap_hit (cap_hit)
   );

   lfs_issue #(
      .BEATS  (BEATS),
      .BEAT_W (BEAT_W),
      .ADDR_W (ADDR_W)
   ) u_issue (
      .clk        (clk),
      .rst        (rst),
      .busy       (busy),
      .req_hit    (req_hit),
      .line_base  (fill_addr),
      .l2_rd_en   (l2_rd_en),
      .l2_rd_addr (l2_rd_addr)
   );

   lfs_linebuf #(
      .BEATS  (BEATS),
      .BEAT_W (BEAT_W)
   ) u_buf (
      .clk        (clk),
      .rst        (rst),
      .clear      (accept),
      .cap_hit    (cap_hit),
      .rdata      (l2_rdata),
      .beat_valid (beat_valid),
      .beat_idx   (beat_idx),
      .beat_data  (beat_data),
      .beat_have  (beat_have),
      .line_done  (line_done),
      .line_data  (line_data)
   );

   // R9
   fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !$past(accept)) |-> ($stable(fill_addr) && $stable(fill_way)));

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> !miss_ready);

   // R11
   aligned_chk: assert property (@(posedge clk) disable iff (rst)
      fill_addr[OFF_W-1:0] == '0);

endmodule

// File: tb/line_fill_seq_bench.sv
`timescale 1ns/1ps
module line_fill_seq_bench;
   logic         clk = 1'b0;
   logic         rst;
   logic         miss_valid;
   logic         miss_ready;
   logic [31:0]  miss_addr;
   logic [1:0]   miss_way;
   logic         miss_is_instr;
   logic         l2_rd_en;
   logic [31:0]  l2_rd_addr;
   logic [63:0]  l2_rdata;
   logic         beat_valid;
   logic [1:0]   beat_idx;
   logic [63:0]  beat_data;
   logic [3:0]   beat_have;
   logic         line_done;
   logic [255:0] line_data;
   logic [1:0]   fill_way;
   logic         fill_is_instr;
   logic [31:0]  fill_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   line_fill_seq u_line_fill_seq (
      .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
      .miss_addr(miss_addr), .miss_way(miss_way), .miss_is_instr(miss_is_instr),
      .l2_rd_en(l2_rd_en), .l2_rd_addr(l2_rd_addr), .l2_rdata(l2_rdata),
      .beat_valid(beat_valid), .beat_idx(beat_idx), .beat_data(beat_data),
      .beat_have(beat_have), .line_done(line_done), .line_data(line_data),
      .fill_way(fill_way), .fill_is_instr(fill_is_instr), .fill_addr(fill_addr)
   );

   function automatic logic [63:0] gen(input logic [31:0] a);
      return {a ^ 32'h5A5A_C3C3, ~a + 32'h0000_1357};
   endfunction

   // L2 model: data for a request appears 8 cycles after the request cycle
   logic        pv [8];
   logic [31:0] pa [8];
   always @(posedge clk) begin
      pv[0] <= l2_rd_en;
      pa[0] <= l2_rd_addr;
      for (int i = 1; i < 8; i++) begin
         pv[i] <= pv[i-1];
         pa[i] <= pa[i-1];
      end
   end
   assign l2_rdata = pv[7] ? gen(pa[7]) : 64'h0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset;
      rst = 1'b1; miss_valid = 1'b0; miss_addr = '0; miss_way = '0; miss_is_instr = 1'b0;
      for (int i = 0; i < 8; i++) begin pv[i] = 1'b0; pa[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      @(negedge clk);
      chk(miss_ready == 1'b1, "R1", "ready", miss_ready, 1);
      chk(beat_valid == 1'b0, "R1", "beat_valid", beat_valid, 0);
      chk(line_done == 1'b0, "R1", "line_done", line_done, 0);
      chk(l2_rd_en == 1'b0, "R1", "l2_rd_en", l2_rd_en, 0);
      chk(beat_have == 4'h0, "R1", "beat_have", beat_have, 0);
   endtask

   task automatic run_fill(input logic [31:0] addr, input logic [1:0] way,
                           input logic instr, input bit poke);
      logic [31:0] base;
      @(negedge clk);
      miss_valid = 1'b1; miss_addr = addr; miss_way = way; miss_is_instr = instr;
      @(posedge clk);
      base = {addr[31:5], 5'b0};
      for (int cyc = 0; cyc <= 15; cyc++) begin
         @(negedge clk);
         if (cyc == 0) miss_valid = 1'b0;
         if (poke && cyc == 4) begin
            miss_valid = 1'b1; miss_addr = addr ^ 32'h0000_1040; miss_way = ~way;
            miss_is_instr = ~instr;
         end
         if (poke && cyc == 12) miss_valid = 1'b0;
         begin
            bit exp_rd;
            bit exp_bv;
            int k;
            exp_rd = (cyc <= 6) && (cyc % 2 == 0);
            exp_bv = (cyc >= 9) && ((cyc - 9) % 2 == 0);
            k = (cyc - 9) / 2;
            chk(l2_rd_en == exp_rd, "R3", $sformatf("rd_en cyc%0d", cyc), l2_rd_en, exp_rd);
            if (exp_rd)
               chk(l2_rd_addr == base + 32'(8 * (cyc / 2)), "R3", "rd_addr",
                   l2_rd_addr, base + 32'(8 * (cyc / 2)));
            chk(beat_valid == exp_bv, (cyc <= 9) ? "R4" : "R5",
                $sformatf("beat_valid cyc%0d", cyc), beat_valid, exp_bv);
            if (exp_bv) begin
               chk(beat_idx == 2'(k), "R5", "beat_idx", beat_idx, k);
               chk(beat_data == gen(base + 32'(8 * k)), "R6", "beat_data",
                   beat_data, gen(base + 32'(8 * k)));
               chk(beat_have == 4'((1 << (k + 1)) - 1), "R8", "beat_have",
                   beat_have, (1 << (k + 1)) - 1);
            end
            if (cyc == 0) chk(beat_have == 4'h0, "R8", "have cleared", beat_have, 0);
            chk(miss_ready == (cyc == 15), "R2", $sformatf("ready cyc%0d", cyc),
                miss_ready, (cyc == 15));
            chk(line_done == (cyc == 15), "R7", $sformatf("done cyc%0d", cyc),
                line_done, (cyc == 15));
            chk(fill_addr == base, poke ? "R9" : "R11", "fill_addr", fill_addr, base);
            chk(fill_way == way, "R9", "fill_way", fill_way, way);
            chk(fill_is_instr == instr, "R10", "fill_is_instr", fill_is_instr, instr);
         end
      end
      chk(line_data == {gen(base + 24), gen(base + 16), gen(base + 8), gen(base)},
          "R7", "line_data", line_data,
          {gen(base + 24), gen(base + 16), gen(base + 8), gen(base)});
   endtask

   task automatic t_data_fill;
      run_fill(32'h0001_0000, 2'd1, 1'b0, 1'b0);
   endtask

   task automatic t_instr_misaligned;
      run_fill(32'h0002_345D, 2'd2, 1'b1, 1'b0);
   endtask

   task automatic t_busy_poke;
      run_fill(32'h8000_0FE0, 2'd3, 1'b0, 1'b1);
   endtask

   task automatic t_have_clear;
      run_fill(32'h0000_0020, 2'd0, 1'b1, 1'b0);
   endtask

   task automatic t_reset_mid;
      @(negedge clk);
      miss_valid = 1'b1; miss_addr = 32'h0003_0000; miss_way = 2'd2; miss_is_instr = 1'b0;
      @(posedge clk);
      for (int cyc = 0; cyc <= 10; cyc++) begin
         @(negedge clk);
         if (cyc == 0) miss_valid = 1'b0;
      end
      rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      chk(miss_ready == 1'b1, "R12", "ready after reset", miss_ready, 1);
      chk(beat_have == 4'h0, "R12", "have after reset", beat_have, 0);
      chk(beat_valid == 1'b0, "R12", "beat_valid after reset", beat_valid, 0);
      chk(line_done == 1'b0, "R12", "done after reset", line_done, 0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(beat_valid == 1'b0 && l2_rd_en == 1'b0, "R12", "idle after reset",
             {beat_valid, l2_rd_en}, 0);
      end
   endtask

   initial begin
      t_reset();
      t_data_fill();
      t_instr_misaligned();
      t_busy_poke();
      t_have_clear();
      t_reset_mid();
      t_data_fill();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule